// File: doc/BRIEF.md
# Serial NAND Page Program Sequencer

This block writes whole pages into a serial NAND flash device over a four-wire SPI link, with no help from software once a request starts. A request gives a byte address and a byte length. Both must be multiples of the page size. The page data arrives on a byte stream with a valid/ready handshake. For each page, the sequencer first sets the device's write latch. It then fills the device's on-chip cache in fixed-size chunks, and every chunk carries its own column address. Next it commits the cache to the array row, and then reads the device status until the device reports that it is no longer busy.

If a status read reports a program failure, or if the device is still busy after the allowed number of polls, the sequencer clears the write latch and stops. The done pulse reports a result code and the number of bytes that were committed before the stop. The row starts at the address divided by the page size and goes up by one for each page.

Top module: `nand_pgm_seq`

## Requirements
- R1: While reset is held, cs_no is high, and sck_o, busy_o, done_o and data_ready_o are low.
- R2: If the start address or the length is not a multiple of PAGE_BYTES, the block produces no SPI transaction. It gives a done pulse with err_o = 1 and done_bytes_o = 0.
- R3: An aligned request of length zero produces no SPI transaction. It gives a done pulse with err_o = 0 and done_bytes_o = 0.
- R4: Each page uses this order of transactions, each framed by its own chip-select low period. First, write enable: the single byte 0x06. Then the cache loads. Then program execute: 0x10 followed by a 3-byte row, most significant byte first. Then one or more status reads: 0x0F, 0xC0, then one byte clocked in while 0x00 is sent.
- R5: Each cache load is 0x84, then a 2-byte column (most significant byte first), then exactly CHUNK_BYTES stream bytes in arrival order. Within a page the columns are 0, CHUNK_BYTES, 2*CHUNK_BYTES and so on, up to the page end.
- R6: The first page uses row address/PAGE_BYTES, and each following page uses the next row.
- R7: A status byte with bit 0 set is treated as busy, and any other bit in it is ignored. The block waits POLL_GAP cycles and polls again. After POLL_MAX busy readings it sends write disable (the single byte 0x04) and gives a done pulse with err_o = 2.
- R8: A status byte with bit 0 clear and bit 3 set is a program failure. The block sends 0x04, programs no further page, and gives a done pulse with err_o = 3.
- R9: A status byte with bits 0 and 3 both clear completes the page. After the last page, done pulses with err_o = 0, and the block sends no write disable.
- R10: The SPI link uses mode 0, most significant bit first. sck_o is low whenever cs_no is high, and mosi_o does not change while sck_o is high.
- R11: data_ready_o is high only while a cache load is waiting for its next byte, with cs_no low. A stream that pauses only stretches the transfer.
- R12: done_o lasts one cycle. busy_o is high from an accepted start until the done pulse. A start while busy has no effect. done_bytes_o equals PAGE_BYTES times the number of pages that completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| addr_i | input | ADDR_W | Byte address of the first page |
| len_i | input | LEN_W | Byte length of the request |
| data_i | input | 8 | Stream byte |
| data_valid_i | input | 1 | Stream byte valid |
| data_ready_o | output | 1 | Stream byte accepted when valid is also high |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_bytes_o | output | LEN_W | Bytes committed, valid with done_o |
| err_o | output | 2 | Result code: 0 ok, 1 misaligned, 2 busy timeout, 3 program failure |
| sck_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
A flash model in the bench decodes every chip-select frame, and a reference model built from the requirements predicts the exact byte list of each frame. The stimulus is built to separate the result paths from one another:
- Requests misaligned in the address alone and in the length alone, and a zero-length request, must leave the link silent.
- A single page and a multi-page run starting at a non-trivial row show that the column and row advance correctly. In that run, busy status bytes carry bit 3, which must not be read as a failure, and the stream is throttled.
- A failure on the middle page checks early termination and the partial byte count.
- A device that never goes ready checks the poll limit and the timeout result.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_PFAIL   = 2'd3
  } pgm_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_LHDR, S_LDAT, S_EXEC, S_POLL, S_GAP, S_WRDI, S_DONE
  } pgm_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_LOAD  = 8'h84;
  localparam logic [7:0] OP_EXEC  = 8'h10;
  localparam logic [7:0] OP_GETF  = 8'h0F;
  localparam logic [7:0] REG_STAT = 8'hC0;
  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_PFAIL_BIT = 3;
endpackage

// File: rtl/nand_spi_shift.sv
module nand_spi_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       last_i,
  output logic       rdy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic       active_q, phase_q, last_q, cs_q, done_q;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      last_q   <= 1'b0;
      cs_q     <= 1'b1;
      done_q   <= 1'b0;
      bit_q    <= 3'd0;
      tx_q     <= 8'h00;
      rx_q     <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        bit_q    <= 3'd0;
        tx_q     <= tx_i;
        last_q   <= last_i;
        cs_q     <= 1'b0;
      end else if (active_q) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          // falling edge: capture slave bit, present next master bit
          phase_q <= 1'b0;
          rx_q    <= {rx_q[6:0], miso_i};
          tx_q    <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            if (last_q) cs_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end
    end
  end

  assign rdy_o  = !active_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = active_q & phase_q;
  assign cs_no  = cs_q;
  assign mosi_o = tx_q[7];
endmodule

// File: rtl/nand_pgm_frame.sv
module nand_pgm_frame
  import nand_pgm_pkg::*;
#(
  parameter int ROW_W = 24
) (
  input  pgm_state_e       state_i,
  input  logic [1:0]       idx_i,
  input  logic [15:0]      col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [7:0]       data_i,
  input  logic             chunk_end_i,
  output logic [7:0]       tx_o,
  output logic             last_o
);
  logic [23:0] row24;
  assign row24 = 24'(row_i);

  always_comb begin
    tx_o   = 8'h00;
    last_o = 1'b0;
    unique case (state_i)
      S_WREN: begin tx_o = OP_WREN; last_o = 1'b1; end
      S_WRDI: begin tx_o = OP_WRDI; last_o = 1'b1; end
      S_LHDR: begin
        case (idx_i)
          2'd0:    tx_o = OP_LOAD;
          2'd1:    tx_o = col_i[15:8];
          default: tx_o = col_i[7:0];
        endcase
      end
      S_LDAT: begin tx_o = data_i; last_o = chunk_end_i; end
      S_EXEC: begin
        case (idx_i)
          2'd0:    tx_o = OP_EXEC;
          2'd1:    tx_o = row24[23:16];
          2'd2:    tx_o = row24[15:8];
          default: tx_o = row24[7:0];
        endcase
        last_o = (idx_i == 2'd3);
      end
      S_POLL: begin
        case (idx_i)
          2'd0:    tx_o = OP_GETF;
          2'd1:    tx_o = REG_STAT;
          default: tx_o = 8'h00;
        endcase
        last_o = (idx_i == 2'd2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_pgm_ctrl.sv
module nand_pgm_ctrl
  import nand_pgm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int ROW_W       = 24,
  parameter int PAGE_BYTES  = 2048,
  parameter int CHUNK_BYTES = 32,
  parameter int POLL_MAX    = 200,
  parameter int POLL_GAP    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              data_valid_i,
  input  logic              eng_rdy_i,
  input  logic              eng_done_i,
  input  logic              st_busy_i,
  input  logic              st_fail_i,
  output logic              go_o,
  output pgm_state_e        state_o,
  output logic [1:0]        idx_o,
  output logic [15:0]       col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              chunk_end_o,
  output logic              data_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  done_bytes_o,
  output logic [1:0]        err_o
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int CHUNK_W    = $clog2(CHUNK_BYTES);
  localparam int PG_W       = LEN_W - PAGE_SHIFT;
  localparam int POLL_W     = $clog2(POLL_MAX + 1);
  localparam int GAP_W      = $clog2(POLL_GAP + 1);

  pgm_state_e         state_q;
  pgm_err_e           err_q;
  logic [1:0]         idx_q;
  logic [15:0]        col_q;
  logic [ROW_W-1:0]   row_q;
  logic [PG_W-1:0]    pages_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic [POLL_W-1:0]  poll_q;
  logic [GAP_W-1:0]   gap_q;
  logic [LEN_W-1:0]   bytes_q;

  logic can_go, byte_state, misalign, page_end;

  assign can_go     = eng_rdy_i & ~eng_done_i;
  assign byte_state = (state_q == S_WREN) || (state_q == S_LHDR) || (state_q == S_LDAT) ||
                      (state_q == S_EXEC) || (state_q == S_POLL) || (state_q == S_WRDI);
  assign go_o       = can_go & byte_state & ((state_q != S_LDAT) | data_valid_i);
  assign misalign   = (|addr_i[PAGE_SHIFT-1:0]) | (|len_i[PAGE_SHIFT-1:0]);
  assign chunk_end_o = (chunk_q == CHUNK_W'(CHUNK_BYTES - 1));
  assign page_end   = (col_q == 16'(PAGE_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= ERR_NONE;
      idx_q   <= 2'd0;
      col_q   <= 16'd0;
      row_q   <= '0;
      pages_q <= '0;
      chunk_q <= '0;
      poll_q  <= '0;
      gap_q   <= '0;
      bytes_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          bytes_q <= '0;
          if (misalign) begin
            err_q   <= ERR_ALIGN;
            state_q <= S_DONE;
          end else if (len_i == '0) begin
            err_q   <= ERR_NONE;
            state_q <= S_DONE;
          end else begin
            err_q   <= ERR_NONE;
            row_q   <= ROW_W'(addr_i >> PAGE_SHIFT);
            pages_q <= PG_W'(len_i >> PAGE_SHIFT);
            state_q <= S_WREN;
          end
        end
        S_WREN: if (eng_done_i) begin
          state_q <= S_LHDR;
          idx_q   <= 2'd0;
          col_q   <= 16'd0;
          chunk_q <= '0;
        end
        S_LHDR: if (eng_done_i) begin
          if (idx_q == 2'd2) begin
            idx_q   <= 2'd0;
            state_q <= S_LDAT;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_LDAT: if (eng_done_i) begin
          col_q   <= col_q + 16'd1;
          chunk_q <= chunk_q + CHUNK_W'(1);
          if (chunk_end_o) begin
            idx_q   <= 2'd0;
            state_q <= page_end ? S_EXEC : S_LHDR;
          end
        end
        S_EXEC: if (eng_done_i) begin
          if (idx_q == 2'd3) begin
            idx_q   <= 2'd0;
            poll_q  <= '0;
            state_q <= S_POLL;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_POLL: if (eng_done_i) begin
          if (idx_q == 2'd2) begin
            idx_q  <= 2'd0;
            poll_q <= poll_q + POLL_W'(1);
            if (!st_busy_i) begin
              if (st_fail_i) begin
                err_q   <= ERR_PFAIL;
                state_q <= S_WRDI;
              end else begin
                bytes_q <= bytes_q + LEN_W'(PAGE_BYTES);
                row_q   <= row_q + ROW_W'(1);
                pages_q <= pages_q - PG_W'(1);
                state_q <= (pages_q == PG_W'(1)) ? S_DONE : S_WREN;
              end
            end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
              err_q   <= ERR_TIMEOUT;
              state_q <= S_WRDI;
            end else begin
              gap_q   <= '0;
              state_q <= S_GAP;
            end
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_GAP: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_q == GAP_W'(POLL_GAP - 1)) state_q <= S_POLL;
        end
        S_WRDI:  if (eng_done_i) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign idx_o        = idx_q;
  assign col_o        = col_q;
  assign row_o        = row_q;
  assign data_ready_o = (state_q == S_LDAT) & can_go;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign done_bytes_o = bytes_q;
  assign err_o        = err_q;
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
  import nand_pgm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int ROW_W       = 24,
  parameter int PAGE_BYTES  = 2048,
  parameter int CHUNK_BYTES = 32,
  parameter int POLL_MAX    = 200,
  parameter int POLL_GAP    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  done_bytes_o,
  output logic [1:0]        err_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  pgm_state_e       state;
  logic [1:0]       idx;
  logic [15:0]      col;
  logic [ROW_W-1:0] row;
  logic             chunk_end, go, eng_rdy, eng_done, last;
  logic [7:0]       tx, rx;
  logic             unused_rx;

  assign unused_rx = ^{rx[7:4], rx[2:1]};

  nand_pgm_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .data_valid_i(data_valid_i), .eng_rdy_i(eng_rdy), .eng_done_i(eng_done),
    .st_busy_i(rx[ST_BUSY_BIT]), .st_fail_i(rx[ST_PFAIL_BIT]), .go_o(go),
    .state_o(state), .idx_o(idx), .col_o(col), .row_o(row), .chunk_end_o(chunk_end),
    .data_ready_o(data_ready_o), .busy_o(busy_o), .done_o(done_o),
    .done_bytes_o(done_bytes_o), .err_o(err_o)
  );

  nand_pgm_frame #(.ROW_W(ROW_W)) u_frame (
    .state_i(state), .idx_i(idx), .col_i(col), .row_i(row), .data_i(data_i),
    .chunk_end_i(chunk_end), .tx_o(tx), .last_o(last)
  );

  nand_spi_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .tx_i(tx), .last_i(last),
    .rdy_o(eng_rdy), .done_o(eng_done), .rx_o(rx), .sck_o(sck_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );
endmodule

// File: rtl/nand_pgm_seq_chk.sv
module nand_pgm_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       data_ready_o,
  input logic [1:0] err_o,
  input logic [7:0] done_bytes_lo,
  input logic       sck_o,
  input logic       cs_no,
  input logic       mosi_o
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R10
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R12
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R12
  AST_READY_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> (busy_o && !cs_no)); // R11
  AST_ALIGN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd1) |-> (done_bytes_lo == 8'd0)); // R2
endmodule

bind nand_pgm_seq nand_pgm_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .data_ready_o(data_ready_o), .err_o(err_o), .done_bytes_lo(done_bytes_o[7:0]),
  .sck_o(sck_o), .cs_no(cs_no), .mosi_o(mosi_o)
);

// File: tb/sim_nand_pgm_seq.sv
module sim_nand_pgm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PG   = 128;
  localparam int CK   = 32;
  localparam int PMAX = 4;
  localparam int PGAP = 3;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dvalid = 1'b0, miso = 1'b0;
  logic [31:0] addr = '0, len = '0;
  logic [7:0]  data = '0;
  logic dready, busy, done, sck, cs_n, mosi;
  logic [31:0] dbytes;
  logic [1:0]  err;

  int n_chk = 0, n_err = 0, n_txn = 0, nbits = 0, seed = 3, cyc = 0;
  int exp_q[$], st_q[$], dq[$], cur[$], eg[$];
  bit in_txn = 0, stall_en = 0, fire = 0;
  logic [7:0] shreg = '0, resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_pgm_seq #(.PAGE_BYTES(PG), .CHUNK_BYTES(CK), .POLL_MAX(PMAX), .POLL_GAP(PGAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .data_i(data), .data_valid_i(dvalid), .data_ready_o(dready), .busy_o(busy),
    .done_o(done), .done_bytes_o(dbytes), .err_o(err), .sck_o(sck), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // flash model: frame capture and status response
  always @(negedge cs_n) begin in_txn = 1; cur.delete(); nbits = 0; end
  always @(posedge sck) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) cur.push_back(int'(shreg));
  end
  always @(negedge sck) if (!cs_n && cur.size() >= 2 && cur[0] == 8'h0F && nbits >= 16 && nbits < 24) begin
    if (nbits == 16) resp = (st_q.size() > 0) ? 8'(st_q.pop_front()) : 8'h00;
    miso = resp[23 - nbits];
  end
  always @(posedge cs_n) if (in_txn) begin
    int k;
    bit ok;
    in_txn = 0;
    n_txn++;
    eg.delete();
    while (exp_q.size() > 0 && exp_q[0] != -1) eg.push_back(exp_q.pop_front());
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    ok = (eg.size() == cur.size());
    k = 0;
    for (int i = 0; i < cur.size() && i < eg.size(); i++)
      if (ok && cur[i] != eg[i]) begin ok = 0; k = i; end
    if (eg.size() != cur.size()) k = (cur.size() < eg.size()) ? cur.size() : eg.size();
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R4 R5 R6 frame %0d byte %0d: actual 0x%0h (len %0d) expected 0x%0h (len %0d)",
               n_txn, k, (k < cur.size()) ? cur[k] : -1, cur.size(),
               (k < eg.size()) ? eg[k] : -1, eg.size());
    end
  end

  // per-clock link invariants
  always @(negedge clk) if (rst_n) begin
    cyc++;
    n_chk++;
    if ((cs_n && sck) || (!busy && !cs_n) || (dready && (!busy || cs_n))) begin
      n_err++;
      $display("FAIL R10 R11 cycle %0d: actual cs=%0b sck=%0b busy=%0b ready=%0b expected idle-low sck, ready only in load",
               cyc, cs_n, sck, busy, dready);
    end
  end

  // stream source
  initial forever begin
    @(negedge clk);
    if (fire) void'(dq.pop_front());
    dvalid = (dq.size() > 0) && !(stall_en && (cyc % 3 != 0));
    data = (dq.size() > 0) ? 8'(dq[0]) : 8'h00;
    #1;
    fire = dvalid && dready;
  end

  task automatic push_poll();
    exp_q.push_back(8'h0F); exp_q.push_back(8'hC0); exp_q.push_back(8'h00); exp_q.push_back(-1);
  endtask

  task automatic run_op(input int a, input int l, input int busy_n, input int busy_val,
                        input int fail_pg, input int to_pg, input bit extra, input string tag);
    bit mis;
    int pages, eerr, ebytes, t0, row;
    mis = ((a % PG) != 0) || ((l % PG) != 0);
    pages = mis ? 0 : l / PG;
    eerr = mis ? 1 : 0;
    ebytes = mis ? 0 : l;
    t0 = n_txn;
    for (int p = 0; p < pages; p++) begin
      row = a / PG + p;
      exp_q.push_back(8'h06); exp_q.push_back(-1);
      for (int c = 0; c < PG / CK; c++) begin
        exp_q.push_back(8'h84); exp_q.push_back((c * CK) >> 8); exp_q.push_back((c * CK) & 255);
        for (int b = 0; b < CK; b++) begin
          seed = (seed * 13 + 7) & 255;
          exp_q.push_back(seed); dq.push_back(seed);
        end
        exp_q.push_back(-1);
      end
      exp_q.push_back(8'h10); exp_q.push_back((row >> 16) & 255);
      exp_q.push_back((row >> 8) & 255); exp_q.push_back(row & 255); exp_q.push_back(-1);
      if (p == to_pg) begin
        for (int i = 0; i < PMAX; i++) begin st_q.push_back(busy_val); push_poll(); end
        exp_q.push_back(8'h04); exp_q.push_back(-1);
        eerr = 2; ebytes = p * PG;
        break;
      end
      for (int i = 0; i < busy_n; i++) begin st_q.push_back(busy_val); push_poll(); end
      push_poll();
      if (p == fail_pg) begin
        st_q.push_back(8'h08);
        exp_q.push_back(8'h04); exp_q.push_back(-1);
        eerr = 3; ebytes = p * PG;
        break;
      end
      st_q.push_back(8'h20);
    end
    @(negedge clk); start = 1; addr = a; len = l;
    @(negedge clk); start = 0;
    if (extra) begin
      repeat (300) @(negedge clk);
      start = 1; addr = 32'h10; len = 32'd1;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk(err == 2'(eerr), {tag, " result code"}, err, eerr);
    chk(dbytes == ebytes, {tag, " R12 byte count"}, dbytes, ebytes);
    @(negedge clk);
    chk(!done, "R12 done single cycle", done, 0);
    chk(!busy && cs_n, "R12 idle after done", busy, 0);
    chk(exp_q.size() == 0, {tag, " R4 all frames seen"}, exp_q.size(), 0);
    chk(dq.size() == 0, "R11 stream fully consumed", dq.size(), 0);
    chk(st_q.size() == 0, "R7 status reads used", st_q.size(), 0);
    if (mis || l == 0) chk(n_txn == t0, {tag, " no SPI frame"}, n_txn - t0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 link idle in reset", {cs_n, sck}, 2);
    chk(busy === 1'b0 && done === 1'b0 && dready === 1'b0, "R1 status low in reset",
        {busy, done, dready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_op(64, PG, 0, 1, -1, -1, 0, "R2 addr");
    run_op(0, 100, 0, 1, -1, -1, 0, "R2 len");
    run_op(2 * PG, 0, 0, 1, -1, -1, 0, "R3");
    run_op(5 * PG, PG, 0, 1, -1, -1, 0, "R9 R5 R6");
    stall_en = 1;
    run_op(32'h123 * PG, 3 * PG, 2, 8'h09, -1, -1, 1, "R7 R11 R6");
    stall_en = 0;
    run_op(7 * PG, 3 * PG, 1, 1, 1, -1, 0, "R8");
    run_op(2 * PG, 2 * PG, 0, 1, -1, 0, 0, "R7 timeout");
    run_op(32'h00FF_FF80, PG, 1, 1, -1, -1, 0, "R6 high row");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule